// File: doc/BRIEF.md
# Radix-4 Signed-Digit Fraction Divider

This block divides one normalized binary fraction by another and retires two quotient bits per iteration. Each step picks a signed quotient digit from {-2, -1, 0, +1, +2} and forms the next partial remainder as four times the old one minus the digit times the divisor. Only the divisor and its doubled copy are ever added or subtracted, so no three-times multiple has to be prepared. The digit comes from a short subtraction on the top 8 bits of the shifted remainder and the top bits of the divisor. Five candidate remainders are built at full width in parallel, and the digit then picks one of them.

A caller presents a dividend and a divisor, each with its most significant bit set, and pulses `start` while `ready` is high. Digits are kept as a positive vector and a negative vector. One final cycle subtracts the two vectors and, when the last remainder is negative, applies a single correction step. With W-bit operands the result satisfies dividend·2^(W-2) = quotient·divisor + remainder, where 0 ≤ remainder < divisor. The quotient and the remainder stay on the outputs until the next result replaces them.

Top module: `radix4_divider`

## Requirements
- R1: After reset, `ready` is 1, `done` is 0, and `quotient` and `remainder` are 0.
- R2: When `start` is high in a cycle where `ready` is high, the block captures `dividend` and `divisor`. `ready` is low from the next cycle until the result appears.
- R3: `done` is a one-cycle pulse that appears exactly W/2+1 clock edges after the accepting edge (9 for W=16). `ready` returns high in the same cycle.
- R4: For operands whose bit W-1 is set, `quotient` equals floor(dividend·2^(W-2) / divisor).
- R5: `remainder` equals dividend·2^(W-2) − quotient·divisor, and lies in 0 ≤ remainder < divisor.
- R6: Every quotient digit lies in {-2..+2}. The internal partial remainder never exceeds two thirds of the divisor in magnitude.
- R7: A `start` pulse while `ready` is low is ignored. The running division finishes with its original operands, and no extra result follows.
- R8: `quotient` and `remainder` hold their last values in every cycle other than the one in which a new result is written.
- R9: The extreme operands give exact results: equal operands give quotient 2^(W-2) with remainder 0, and all-ones over 2^(W-1) gives quotient 2^(W-1)-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to begin a division |
| dividend | input | W | Normalized dividend fraction, bit W-1 set |
| divisor | input | W | Normalized divisor fraction, bit W-1 set |
| ready | output | 1 | Block is idle and will accept `start` |
| done | output | 1 | One-cycle pulse: new result on the outputs |
| quotient | output | W | floor(dividend·2^(W-2)/divisor) |
| remainder | output | W | Final non-negative remainder |

## Verification
A wrong digit choice, or a remainder that leaves its bound, is invisible until the result cycle. It then shows as a quotient or remainder that differs from the exact integer division, W/2+1 cycles after acceptance. The bench therefore compares both outputs against an exact integer reference in every cycle. Operands sit at both ends of the normalized range, where the selection margins are tightest. A miscounted iteration or a wrong state shows within one cycle as `ready` or `done` out of step with the reference timing. A handshake fault shows as a result computed from operands that were offered while the block was busy.

// File: rtl/radix4_div_pkg.sv
package radix4_div_pkg;

  // fraction bits kept by the digit estimate, and the estimate width
  localparam int unsigned EST_FRAC = 5;
  localparam int unsigned EST_W    = EST_FRAC + 3;

  // signed quotient digit, legal values -2..+2
  typedef logic signed [2:0] digit_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

endpackage

// File: rtl/r4_digit_sel.sv
module r4_digit_sel
  import radix4_div_pkg::*;
(
  input  logic signed [EST_W-1:0]    est,
  input  logic        [EST_FRAC-1:0] dtop,
  output digit_t                     dig
);

  // compare 2*est against +-1 and +-3 times the truncated divisor
  localparam int CW = EST_W + 2;

  logic signed [CW-1:0] e2;
  logic signed [CW-1:0] dx1;
  logic signed [CW-1:0] dx3;
  logic signed [CW-1:0] t_p2, t_p1, t_z, t_m1;

  always_comb begin
    e2   = {{(CW-EST_W-1){est[EST_W-1]}}, est, 1'b0};
    dx1  = {{(CW-EST_FRAC){1'b0}}, dtop};
    dx3  = dx1 + {dx1[CW-2:0], 1'b0};
    t_p2 = e2 - dx3;
    t_p1 = e2 - dx1;
    t_z  = e2 + dx1;
    t_m1 = e2 + dx3;
    if (!t_p2[CW-1])      dig = 3'b010;
    else if (!t_p1[CW-1]) dig = 3'b001;
    else if (!t_z[CW-1])  dig = 3'b000;
    else if (!t_m1[CW-1]) dig = 3'b111;
    else                  dig = 3'b110;
  end

endmodule

// File: rtl/r4_rem_step.sv
module r4_rem_step
  import radix4_div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W+5:0]     rem,
  input  logic        [W-1:0]     dvs,
  input  digit_t                  dig,
  output logic signed [EST_W-1:0] est,
  output logic signed [W+5:0]     rem_nxt
);

  localparam int RW = W + 6;

  logic signed [RW-1:0] ws;
  logic signed [RW-1:0] dm1;
  logic signed [RW-1:0] dm2;
  logic signed [RW-1:0] cand [5];

  // remainder is kept in units of 2^-(W+2), so the divisor is scaled by 4
  assign ws  = rem <<< 2;
  assign dm1 = {{(RW-W-2){1'b0}}, dvs, 2'b00};
  assign dm2 = dm1 <<< 1;

  // top bits of 4r, truncated to EST_FRAC fraction bits
  assign est = ws[W+4 -: EST_W];

  // all five candidate remainders built in parallel with digit selection
  for (genvar k = 0; k < 5; k++) begin : g_cand
    localparam int SD = k - 2;
    if (SD == 0) begin : g_zero
      assign cand[k] = ws;
    end else if (SD == 1) begin : g_p1
      assign cand[k] = ws - dm1;
    end else if (SD == 2) begin : g_p2
      assign cand[k] = ws - dm2;
    end else if (SD == -1) begin : g_m1
      assign cand[k] = ws + dm1;
    end else begin : g_m2
      assign cand[k] = ws + dm2;
    end
  end

  always_comb begin
    case (dig)
      3'b010:  rem_nxt = cand[4];
      3'b001:  rem_nxt = cand[3];
      3'b111:  rem_nxt = cand[1];
      3'b110:  rem_nxt = cand[0];
      default: rem_nxt = cand[2];
    endcase
  end

endmodule

// File: rtl/r4_qacc.sv
module r4_qacc
  import radix4_div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  digit_t       dig,
  output logic [W-1:0] qp,
  output logic [W-1:0] qn
);

  logic [W-1:0] qp_d, qn_d;
  logic [1:0]   pos_bits, neg_bits;
  logic [2:0]   negd;
  logic         upd;

  always_comb begin
    negd     = 3'b000 - dig;
    pos_bits = dig[2] ? 2'b00 : dig[1:0];
    neg_bits = dig[2] ? negd[1:0] : 2'b00;
    upd      = clr | en;
    if (clr) begin
      qp_d = '0;
      qn_d = '0;
    end else begin
      qp_d = {qp[W-3:0], pos_bits};
      qn_d = {qn[W-3:0], neg_bits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qp <= '0;
      qn <= '0;
    end else if (upd) begin
      qp <= qp_d;
      qn <= qn_d;
    end
  end

endmodule

// File: rtl/radix4_divider.sv
module radix4_divider
  import radix4_div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         ready,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);

  localparam int K  = W / 2;
  localparam int RW = W + 6;
  localparam int CW = (K > 1) ? $clog2(K) : 1;

  // reset synchronizer: asserted at once, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  div_state_e           state_q, state_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic signed [RW-1:0] rem_q, rem_d;
  logic [W-1:0]         dvs_q, dvs_d;
  logic [W-1:0]         quo_q, quo_d;
  logic [W-1:0]         rmd_q, rmd_d;
  logic                 done_q, done_d;
  logic                 rem_en, dvs_en, out_en, q_clr, q_en;

  logic signed [EST_W-1:0] est;
  logic signed [RW-1:0]    rem_step;
  digit_t                  dig;
  logic [W-1:0]            qp, qn, qdiff;
  logic signed [RW-1:0]    rem_fix;

  r4_rem_step #(.W(W)) u_step (
    .rem     (rem_q),
    .dvs     (dvs_q),
    .dig     (dig),
    .est     (est),
    .rem_nxt (rem_step)
  );

  r4_digit_sel u_sel (
    .est  (est),
    .dtop (dvs_q[W-1 -: EST_FRAC]),
    .dig  (dig)
  );

  r4_qacc #(.W(W)) u_qacc (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (q_clr),
    .en    (q_en),
    .dig   (dig),
    .qp    (qp),
    .qn    (qn)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    dvs_d   = dvs_q;
    quo_d   = quo_q;
    rmd_d   = rmd_q;
    done_d  = 1'b0;
    rem_en  = 1'b0;
    dvs_en  = 1'b0;
    out_en  = 1'b0;
    q_clr   = 1'b0;
    q_en    = 1'b0;
    qdiff   = qp - qn;
    rem_fix = rem_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          cnt_d   = '0;
          rem_d   = {{(RW-W){1'b0}}, dividend};
          dvs_d   = divisor;
          rem_en  = 1'b1;
          dvs_en  = 1'b1;
          q_clr   = 1'b1;
        end
      end
      ST_RUN: begin
        rem_d  = rem_step;
        rem_en = 1'b1;
        q_en   = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == CW'(K-1)) state_d = ST_FIN;
      end
      ST_FIN: begin
        if (rem_q[RW-1]) begin
          rem_fix = rem_q + {{(RW-W-2){1'b0}}, dvs_q, 2'b00};
          quo_d   = qdiff - 1'b1;
        end else begin
          quo_d   = qdiff;
        end
        rmd_d   = rem_fix[W+1:2];
        out_en  = 1'b1;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rem_q <= '0;
      dvs_q <= '0;
    end else begin
      if (rem_en) rem_q <= rem_d;
      if (dvs_en) dvs_q <= dvs_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      quo_q <= '0;
      rmd_q <= '0;
    end else if (out_en) begin
      quo_q <= quo_d;
      rmd_q <= rmd_d;
    end
  end

  assign ready     = (state_q == ST_IDLE);
  assign done      = done_q;
  assign quotient  = quo_q;
  assign remainder = rmd_q;

  // checks
  logic [RW-1:0] rem_abs;
  logic [RW+1:0] bound_lhs, bound_rhs;
  assign rem_abs   = rem_q[RW-1] ? unsigned'(-rem_q) : unsigned'(rem_q);
  assign bound_lhs = {2'b00, rem_abs} + {1'b0, rem_abs, 1'b0};
  assign bound_rhs = {{(RW+2-W-3){1'b0}}, dvs_q, 3'b000};

  a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_i_n)
    (start && ready) |=> !ready);

  a_r3_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> !done);

  a_r3_ready_with_done: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |-> ready);

  a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |-> (remainder < dvs_q));

  a_r6_digit_range: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_RUN) |-> (dig != 3'b011 && dig != 3'b100 && dig != 3'b101));

  a_r6_rem_bound: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q != ST_IDLE) |-> (bound_lhs <= bound_rhs));

  a_r8_hold_outputs: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q != ST_FIN) |=> ($stable(quotient) && $stable(remainder)));

endmodule

// File: tb/sim_radix4_divider.sv
module sim_radix4_divider;

  localparam int W = 16;
  localparam int K = W / 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         ready, done;
  logic [W-1:0] quotient, remainder;

  always #10 clk = ~clk;

  radix4_divider #(.W(W)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .ready     (ready),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    checking = 1'b0;
  string cur_tag = "R4";

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_q(input logic [W-1:0] n, input logic [W-1:0] d);
    longint num;
    longint q;
    num = longint'(n) << (W-2);
    q   = num / longint'(d);
    return q[W-1:0];
  endfunction

  function automatic logic [W-1:0] ref_r(input logic [W-1:0] n, input logic [W-1:0] d);
    longint num;
    longint r;
    num = longint'(n) << (W-2);
    r   = num % longint'(d);
    return r[W-1:0];
  endfunction

  // behavioural timing and value model
  int           m_cnt;
  logic         m_done;
  logic [W-1:0] m_q, m_r, m_q_out, m_r_out;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt   <= 0;
      m_done  <= 1'b0;
      m_q     <= '0;
      m_r     <= '0;
      m_q_out <= '0;
      m_r_out <= '0;
    end else begin
      m_done <= (m_cnt == 1);
      if (m_cnt == 1) begin
        m_q_out <= m_q;
        m_r_out <= m_r;
      end
      if (m_cnt == 0 && start) begin
        m_cnt <= K + 1;
        m_q   <= ref_q(dividend, divisor);
        m_r   <= ref_r(dividend, divisor);
      end else if (m_cnt > 0) begin
        m_cnt <= m_cnt - 1;
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (checking) begin
      chk(ready == (m_cnt == 0), "R2", longint'(ready), longint'(m_cnt == 0));
      chk(done == m_done, "R3", longint'(done), longint'(m_done));
      chk(quotient == m_q_out, m_done ? cur_tag : "R8", longint'(quotient), longint'(m_q_out));
      chk(remainder == m_r_out, m_done ? "R5" : "R8", longint'(remainder), longint'(m_r_out));
      if (m_done) chk(remainder < divisor_seen, "R5", longint'(remainder), longint'(divisor_seen));
    end
  end

  logic [W-1:0] divisor_seen = '1;
  always @(posedge clk) if (m_cnt == 0 && start && rst_n) divisor_seen <= divisor;

  task automatic issue(input logic [W-1:0] n, input logic [W-1:0] d);
    @(negedge clk);
    while (!ready) @(negedge clk);
    start    = 1'b1;
    dividend = n;
    divisor  = d;
    @(negedge clk);
    start    = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_cnt != 0 || m_done) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R3 watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ready == 1'b1, "R1", longint'(ready), 1);
    chk(done == 1'b0, "R1", longint'(done), 0);
    chk(quotient == '0, "R1", longint'(quotient), 0);
    chk(remainder == '0, "R1", longint'(remainder), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checking = 1'b1;

    // R4/R5: directed mid-range operands
    cur_tag = "R4";
    issue(16'hC000, 16'hA000);
    issue(16'h9ABC, 16'hF123);
    issue(16'hF123, 16'h9ABC);
    issue(16'hAAAA, 16'hD555);
    wait_idle();

    // R9 and R6: ends of the normalized range, tightest selection margins
    cur_tag = "R9";
    issue(16'h8000, 16'h8000);
    issue(16'hFFFF, 16'hFFFF);
    issue(16'hFFFF, 16'h8000);
    issue(16'h8000, 16'hFFFF);
    issue(16'hFFFF, 16'h8001);
    issue(16'h8001, 16'hFFFF);
    wait_idle();
    chk(m_q_out == ref_q(16'h8001, 16'hFFFF), "R9", longint'(m_q_out),
        longint'(ref_q(16'h8001, 16'hFFFF)));
    chk(ref_q(16'h8000, 16'h8000) == 16'h4000, "R9",
        longint'(ref_q(16'h8000, 16'h8000)), 16384);
    chk(ref_q(16'hFFFF, 16'h8000) == 16'h7FFF, "R9",
        longint'(ref_q(16'hFFFF, 16'h8000)), 32767);

    // R7: start while busy is ignored
    cur_tag = "R7";
    issue(16'hB000, 16'h9000);
    repeat (3) @(negedge clk);
    start    = 1'b1;
    dividend = 16'h8000;
    divisor  = 16'hFFFF;
    repeat (2) @(negedge clk);
    start    = 1'b0;
    wait_idle();
    chk(quotient == ref_q(16'hB000, 16'h9000), "R7", longint'(quotient),
        longint'(ref_q(16'hB000, 16'h9000)));

    // R8: outputs hold while idle
    repeat (5) @(negedge clk);

    // R4/R5/R6: random normalized operands, back to back
    cur_tag = "R4";
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] rn, rd;
      rn = W'($urandom) | {1'b1, {(W-1){1'b0}}};
      rd = W'($urandom) | {1'b1, {(W-1){1'b0}}};
      issue(rn, rd);
    end
    wait_idle();
    repeat (3) @(negedge clk);

    checking = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule